// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind a bus front end that has already turned write strobes into single-cycle byte-load events, each carrying an address and a data byte. It follows that stream and spots the short command sequences that guard a sector-programmed nonvolatile array. Four commands are recognised: a three-step prefix that arms write protection, a six-step sequence that removes it, and two three-step sequences that enter and leave identification mode. Command bytes are consumed. Every other load is classified, one cycle later, as either a real data store or a timer-only write.

A timer-only write makes the program timer run but must leave the array unchanged. That is the case for any load made while protection is on and no prefix opened a write window. The protect flag is built to survive: only a dedicated power-on reset clears it, and it changes state only when the program cycle that follows its command ends. The end of that cycle is reported on `cyc_done`. In identification mode the block answers reads of the two lowest locations with a manufacturer byte and a device byte.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After both resets, `prot_on`, `id_on`, `id_hit` and all four result pulses are 0.
- R2: The loads 0xAA at 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555 each raise `cmd_taken`. The last of the three also raises `wr_permit`. `prot_on` goes to 1 only on the clock after the next `cyc_done` pulse.
- R3: While `prot_on` is 1 and no write window is open, an ordinary load raises `timer_only` and not `data_store`.
- R4: A completed enable or disable sequence opens a write window. Within that window, ordinary loads raise `data_store` even when protected. The next `cyc_done` closes the window.
- R5: The loads AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555 are each consumed, and the last raises `wr_permit`. `prot_on` falls to 0 only after the next `cyc_done`.
- R6: After AA/5555 and 55/2AAA, a third load of 0x90 at 0x5555 sets `id_on` and a third load of 0xF0 at 0x5555 clears it. Both take effect on the same clock as their `cmd_taken` pulse.
- R7: `id_hit` is 1 only when `id_on` is 1 and `rd_addr` bits 15..1 are all zero. `id_byte` is then 0x1F for `rd_addr[0]`=0 and 0x5D for `rd_addr[0]`=1, and 0 whenever `id_hit` is 0.
- R8: A load that does not match the expected next step sends the matcher back to idle and is handled as an ordinary load. Such a load raises `data_store` when unprotected and `timer_only` when protected.
- R9: Only address bits 14..0 take part in step matching, so bit 15 is ignored.
- R10: `prot_on` holds its value across `rst_n` pulses and across `cyc_done` pulses that follow no command. Only `por_n` clears it. `rst_n` clears `id_on`.
- R11: Each load gives exactly one of `cmd_taken`, `data_store`, `timer_only`, one clock after `ld_valid`. No pulse occurs without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous; clears matcher, window and ID mode |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the protect flag |
| ld_valid | input | 1 | One-cycle byte-load event |
| ld_addr | input | 16 | Address of the byte load |
| ld_data | input | 8 | Data of the byte load |
| cyc_done | input | 1 | Pulse marking the end of a program cycle |
| rd_addr | input | 16 | Read address used for identification readout |
| prot_on | output | 1 | Write protection active |
| id_on | output | 1 | Identification mode active |
| wr_permit | output | 1 | Pulse: a sequence completed and the next sector load is permitted |
| cmd_taken | output | 1 | Pulse: the load was consumed as a command step |
| data_store | output | 1 | Pulse: the load may modify the array |
| timer_only | output | 1 | Pulse: run the write timer, but modify no data |
| id_hit | output | 1 | The read address hits an identification byte |
| id_byte | output | 8 | Identification byte, 0 when there is no hit |

## Verification
The bench sweeps all 256 values of the third step after the common two-step prefix. A decoder that confused 0x80 with 0xA0, or treated an unknown third byte as a command, would misclassify a load in that sweep. It then corrupts each of the six disable steps in turn while protection is on. A matcher that stayed mid-sequence, or that stored the corrupted byte, would report `cmd_taken` or `data_store` where `timer_only` is due. The bench also checks that protection flips exactly one clock after `cyc_done` and not at the command itself. An early flip would protect or expose the very sector load the command was meant to cover. Finally, it checks that a soft reset leaves protection set, that bit 15 of the address is ignored, and that an address with bit 15 set misses the identification bytes.

// File: rtl/ucd_pkg.sv
`timescale 1ns/1ps
package ucd_pkg;
  localparam int MATCH_W = 15;
  localparam int CODE_W  = 8;

  localparam logic [MATCH_W-1:0] ADR_HI = 15'h5555;
  localparam logic [MATCH_W-1:0] ADR_LO = 15'h2AAA;

  localparam logic [CODE_W-1:0] K_LEAD  = 8'hAA;
  localparam logic [CODE_W-1:0] K_SEC   = 8'h55;
  localparam logic [CODE_W-1:0] K_LOCK  = 8'hA0;
  localparam logic [CODE_W-1:0] K_EXT   = 8'h80;
  localparam logic [CODE_W-1:0] K_FREE  = 8'h20;
  localparam logic [CODE_W-1:0] K_IDIN  = 8'h90;
  localparam logic [CODE_W-1:0] K_IDOUT = 8'hF0;

  localparam logic [CODE_W-1:0] ID_MAKER  = 8'h1F;
  localparam logic [CODE_W-1:0] ID_DEVICE = 8'h5D;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5
  } step_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_DATA, EV_STEP, EV_LOCK, EV_UNLOCK, EV_ID_IN, EV_ID_OUT
  } ev_e;

  function automatic logic key_hit(input logic [MATCH_W-1:0] a,
                                   input logic [CODE_W-1:0]  d,
                                   input logic [MATCH_W-1:0] ea,
                                   input logic [CODE_W-1:0]  ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic [CODE_W-1:0] id_code(input logic sel);
    return sel ? ID_DEVICE : ID_MAKER;
  endfunction
endpackage

// File: rtl/ucd_step_fsm.sv
`timescale 1ns/1ps
module ucd_step_fsm import ucd_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [CODE_W-1:0]    ld_data,
  output ev_e                  ev
);
  step_e st, nxt;
  logic [MATCH_W-1:0] a;

  assign a = ld_addr[MATCH_W-1:0];

  always_comb begin
    nxt = ST_IDLE;
    ev  = EV_DATA;
    unique case (st)
      ST_IDLE: if (key_hit(a, ld_data, ADR_HI, K_LEAD)) begin nxt = ST_K1; ev = EV_STEP; end
      ST_K1:   if (key_hit(a, ld_data, ADR_LO, K_SEC))  begin nxt = ST_K2; ev = EV_STEP; end
      ST_K2: begin
        if      (key_hit(a, ld_data, ADR_HI, K_LOCK))  ev = EV_LOCK;
        else if (key_hit(a, ld_data, ADR_HI, K_IDIN))  ev = EV_ID_IN;
        else if (key_hit(a, ld_data, ADR_HI, K_IDOUT)) ev = EV_ID_OUT;
        else if (key_hit(a, ld_data, ADR_HI, K_EXT)) begin nxt = ST_X3; ev = EV_STEP; end
      end
      ST_X3:   if (key_hit(a, ld_data, ADR_HI, K_LEAD)) begin nxt = ST_X4; ev = EV_STEP; end
      ST_X4:   if (key_hit(a, ld_data, ADR_LO, K_SEC))  begin nxt = ST_X5; ev = EV_STEP; end
      ST_X5:   if (key_hit(a, ld_data, ADR_HI, K_FREE)) ev = EV_UNLOCK;
      default: ;
    endcase
    if (!ld_valid) begin
      nxt = st;
      ev  = EV_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/ucd_mode_regs.sv
`timescale 1ns/1ps
module ucd_mode_regs import ucd_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  ev_e  ev,
  input  logic cyc_done,
  output logic prot_on,
  output logic id_on,
  output logic window,
  output logic wr_permit,
  output logic cmd_taken,
  output logic data_store,
  output logic timer_only
);
  logic pend_en, pend_dis;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prot_on <= 1'b0;
    else if (cyc_done) begin
      if (pend_en)       prot_on <= 1'b1;
      else if (pend_dis) prot_on <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en <= 1'b0; pend_dis <= 1'b0; window <= 1'b0; id_on <= 1'b0;
      wr_permit <= 1'b0; cmd_taken <= 1'b0; data_store <= 1'b0; timer_only <= 1'b0;
    end else begin
      wr_permit <= 1'b0; cmd_taken <= 1'b0; data_store <= 1'b0; timer_only <= 1'b0;
      if (cyc_done) begin
        pend_en <= 1'b0; pend_dis <= 1'b0; window <= 1'b0;
      end
      unique case (ev)
        EV_STEP:   cmd_taken <= 1'b1;
        EV_LOCK: begin
          cmd_taken <= 1'b1; wr_permit <= 1'b1;
          pend_en <= 1'b1; pend_dis <= 1'b0; window <= 1'b1;
        end
        EV_UNLOCK: begin
          cmd_taken <= 1'b1; wr_permit <= 1'b1;
          pend_dis <= 1'b1; pend_en <= 1'b0; window <= 1'b1;
        end
        EV_ID_IN:  begin cmd_taken <= 1'b1; id_on <= 1'b1; end
        EV_ID_OUT: begin cmd_taken <= 1'b1; id_on <= 1'b0; end
        EV_DATA: begin
          if (!prot_on || window) data_store <= 1'b1;
          else                    timer_only <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ucd_id_port.sv
`timescale 1ns/1ps
module ucd_id_port import ucd_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic               id_on,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               id_hit,
  output logic [CODE_W-1:0]  id_byte
);
  localparam int UP_W = ADDR_W - 1;
  logic [UP_W-1:0] upper;

  assign upper   = rd_addr[ADDR_W-1:1];
  assign id_hit  = id_on && (upper == '0);
  assign id_byte = id_hit ? id_code(rd_addr[0]) : '0;
endmodule

// File: rtl/unlock_seq_decoder.sv
`timescale 1ns/1ps
module unlock_seq_decoder import ucd_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              cyc_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              id_on,
  output logic              wr_permit,
  output logic              cmd_taken,
  output logic              data_store,
  output logic              timer_only,
  output logic              id_hit,
  output logic [7:0]        id_byte
);
  ev_e  step_ev;
  logic open_win;

  ucd_step_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data), .ev(step_ev)
  );

  ucd_mode_regs regs_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ev(step_ev), .cyc_done(cyc_done),
    .prot_on(prot_on), .id_on(id_on), .window(open_win), .wr_permit(wr_permit),
    .cmd_taken(cmd_taken), .data_store(data_store), .timer_only(timer_only)
  );

  ucd_id_port #(.ADDR_W(ADDR_W)) idp_i (
    .id_on(id_on), .rd_addr(rd_addr), .id_hit(id_hit), .id_byte(id_byte)
  );
endmodule

// File: rtl/ucd_checker.sv
`timescale 1ns/1ps
module ucd_checker (
  input logic clk,
  input logic rst_n,
  input logic por_n,
  input logic ld_valid,
  input logic cyc_done,
  input logic prot_on,
  input logic id_on,
  input logic wr_permit,
  input logic cmd_taken,
  input logic data_store,
  input logic timer_only,
  input logic id_hit,
  input logic open_win
);
  p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0({cmd_taken, data_store, timer_only}));

  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cmd_taken || data_store || timer_only) |-> $past(ld_valid));

  p_load_answered_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ld_valid |=> (cmd_taken || data_store || timer_only));

  p_permit_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wr_permit |-> (cmd_taken && open_win));

  p_prot_edge_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !$stable(prot_on) |-> $past(cyc_done));

  p_timer_prot_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    timer_only |-> ($past(prot_on) && !$past(open_win)));

  p_id_rise_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(id_on) |-> cmd_taken);

  p_id_gate_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    id_hit |-> id_on);
endmodule

bind unlock_seq_decoder ucd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .ld_valid(ld_valid), .cyc_done(cyc_done),
  .prot_on(prot_on), .id_on(id_on), .wr_permit(wr_permit), .cmd_taken(cmd_taken),
  .data_store(data_store), .timer_only(timer_only), .id_hit(id_hit), .open_win(open_win)
);

// File: tb/unlock_seq_decoder_tb_top.sv
`timescale 1ns/1ps
module unlock_seq_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
  logic ld_valid = 1'b0, cyc_done = 1'b0;
  logic [15:0] ld_addr = '0, rd_addr = '0;
  logic [7:0]  ld_data = '0;
  logic prot_on, id_on, wr_permit, cmd_taken, data_store, timer_only, id_hit;
  logic [7:0] id_byte;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [3:0] K_CMD = 4'b0100, K_PERMIT = 4'b1100, K_STORE = 4'b0010, K_TIMER = 4'b0001;

  always #2 clk = ~clk;

  unlock_seq_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .cyc_done(cyc_done), .rd_addr(rd_addr), .prot_on(prot_on),
    .id_on(id_on), .wr_permit(wr_permit), .cmd_taken(cmd_taken), .data_store(data_store),
    .timer_only(timer_only), .id_hit(id_hit), .id_byte(id_byte)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] d,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    check(tag, {12'h0, wr_permit, cmd_taken, data_store, timer_only}, {12'h0, exp});
  endtask

  task automatic cycle_end();
    @(negedge clk); cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0;
  endtask

  task automatic enable_prefix(input logic [15:0] hi, input string tag);
    load(hi, 8'hAA, K_CMD, tag);
    load(hi ^ 16'h7FFF, 8'h55, K_CMD, tag);
    load(hi, 8'hA0, K_PERMIT, tag);
  endtask

  function automatic logic [3:0] third_kind(input logic [7:0] d);
    if (d == 8'hA0) return K_PERMIT;
    if (d == 8'h80 || d == 8'h90 || d == 8'hF0) return K_CMD;
    return K_STORE;
  endfunction

  function automatic logic [7:0] dis_data(input int i);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  function automatic logic [15:0] dis_addr(input int i);
    return (i == 1 || i == 4) ? 16'h2AAA : 16'h5555;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    check("R1 prot", {15'h0, prot_on}, 16'h0);
    check("R1 id", {15'h0, id_on}, 16'h0);
    check("R1 pulses", {12'h0, wr_permit, cmd_taken, data_store, timer_only}, 16'h0);
    check("R1 id_hit", {15'h0, id_hit}, 16'h0);

    // R2 R6 R8: every third-step value after the common prefix, then a filler
    for (int v = 0; v < 256; v++) begin
      load(16'h5555, 8'hAA, K_CMD, "R2 step1");
      load(16'h2AAA, 8'h55, K_CMD, "R2 step2");
      load(16'h5555, v[7:0], third_kind(v[7:0]), "R8 third sweep");
      if (v == 8'h90) check("R6 id entry", {15'h0, id_on}, 16'h1);
      if (v == 8'hF0) check("R6 id exit", {15'h0, id_on}, 16'h0);
      load(16'h0000, 8'h00, K_STORE, "R8 filler");
    end
    check("R2 no early protect", {15'h0, prot_on}, 16'h0);
    cycle_end();
    check("R2 protect after cycle", {15'h0, prot_on}, 16'h1);

    load(16'h1234, 8'h3C, K_TIMER, "R3 unprefixed");
    enable_prefix(16'h5555, "R4 prefix");
    load(16'h1280, 8'h11, K_STORE, "R4 windowed store");
    load(16'h1281, 8'h12, K_STORE, "R4 windowed store 2");
    cycle_end();
    load(16'h1282, 8'h13, K_TIMER, "R4 window closed");
    for (int k = 0; k < 3; k++) cycle_end();
    check("R10 persists over idle cycles", {15'h0, prot_on}, 16'h1);

    // R8: corrupt each disable step while protected
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < p; i++) load(dis_addr(i), dis_data(i), K_CMD, "R5 partial");
      load(dis_addr(p), dis_data(p) ^ 8'h01, K_TIMER, "R8 corrupt step");
    end
    check("R8 still protected", {15'h0, prot_on}, 16'h1);

    // R9: bit 15 of the address is ignored
    enable_prefix(16'hD555, "R9 bit15 ignored");
    load(16'h0100, 8'h44, K_STORE, "R9 windowed store");
    cycle_end();

    // R5: full disable
    for (int i = 0; i < 6; i++)
      load(dis_addr(i), dis_data(i), (i == 5) ? K_PERMIT : K_CMD, "R5 disable step");
    check("R5 not yet cleared", {15'h0, prot_on}, 16'h1);
    load(16'h0200, 8'h55, K_STORE, "R5 windowed store");
    cycle_end();
    check("R5 cleared", {15'h0, prot_on}, 16'h0);
    load(16'h0201, 8'h66, K_STORE, "R5 unprotected store");

    // R7: identification readout
    load(16'h5555, 8'hAA, K_CMD, "R6 prefix");
    load(16'h2AAA, 8'h55, K_CMD, "R6 prefix");
    load(16'h5555, 8'h90, K_CMD, "R6 entry");
    foreach (rd_addr[i]) begin
      rd_addr = 16'h1 << i; #1;
      check("R7 id_hit", {15'h0, id_hit}, {15'h0, i == 0});
      check("R7 id_byte", {8'h0, id_byte}, {8'h0, (i == 0) ? 8'h5D : 8'h00});
    end
    rd_addr = 16'h0000; #1;
    check("R7 maker byte", {8'h0, id_byte}, 16'h001F);
    rd_addr = 16'h8001; #1;
    check("R7 bit15 miss", {15'h0, id_hit}, 16'h0);
    rd_addr = 16'h0000;

    // R10: soft reset keeps protection, clears id mode; por clears protection
    enable_prefix(16'h5555, "R10 enable");
    cycle_end();
    check("R10 protected", {15'h0, prot_on}, 16'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 soft reset keeps protect", {15'h0, prot_on}, 16'h1);
    check("R10 soft reset clears id", {15'h0, id_on}, 16'h0);
    load(16'h0300, 8'h77, K_TIMER, "R10 still guarded");
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    #1;
    check("R10 por clears protect", {15'h0, prot_on}, 16'h0);
    load(16'h0301, 8'h78, K_STORE, "R10 store after por");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule